// File: doc/BRIEF.md
# Wiper Position Register with Recall, Load and Step

This block holds the volatile position code of a digitally controlled resistor ladder and turns it into a one-hot tap-select word. Exactly one tap switch is on at any time. Code zero selects the low-end tap, and the all-ones code selects the high-end tap. A command controller drives single-cycle strobes into the block. A host write loads a code directly. A transfer loads the code from one of the bank-0 data registers. A step strobe moves the wiper one tap up or down.

After reset the block waits a fixed number of clocks, shown in the design as state SETTLE, so that the nonvolatile store has settled. It then spends one clock in RECALL, where it copies bank-0 data register 0 into the position. After that it stays in RUN, where it accepts strobes. The transitions are: reset goes to SETTLE; SETTLE goes to RECALL when the wait counter expires; RECALL always goes to RUN; RUN stays in RUN until the next reset. Strobes that arrive in SETTLE or RECALL are dropped.

Top module: `wiper_position`

## Requirements
- R1: While `rst_n` is low, `code` is 0 and `tap_sel` has only bit 0 set. Reset is asynchronous.
- R2: The recall edge is posedge number RECALL_WAIT+1 after reset release. At that edge `code` takes bits [WIDTH-1:0] of `dr_bank0` (register 0).
- R3: Host, transfer and step strobes have no effect on `code` before the recall edge, and none at the recall edge.
- R4: In RUN, `host_wr_en` loads `host_wr_code` into `code` at the next edge.
- R5: In RUN, `xfr_en` loads data register `xfr_sel` into `code`. Register i sits at bits [i*WIDTH +: WIDTH] of `dr_bank0`.
- R6: In RUN, `step_en` with `step_up`=1 adds one to `code`. At the all-ones code the value stays put and does not wrap.
- R7: In RUN, `step_en` with `step_up`=0 subtracts one from `code`. At 0 the value stays put and does not wrap.
- R8: When strobes arrive together, a host write wins over a transfer, and a transfer wins over a step.
- R9: `tap_sel` always has exactly one bit set, at index `code`. It changes on the same edge as `code`.
- R10: In RUN with no strobe, `code` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr_en | input | 1 | Direct load strobe |
| host_wr_code | input | WIDTH | Code for a direct load |
| xfr_en | input | 1 | Load-from-data-register strobe |
| xfr_sel | input | $clog2(NUM_DR) | Bank-0 register index for the transfer |
| step_en | input | 1 | Single-step strobe |
| step_up | input | 1 | 1 steps toward the high end, 0 toward the low end |
| dr_bank0 | input | NUM_DR*WIDTH | Bank-0 data register contents, flattened |
| code | output | WIDTH | Current wiper position |
| tap_sel | output | 2**WIDTH | One-hot tap switch enables |

## Verification
The bench builds the block with WIDTH=4, NUM_DR=4 and RECALL_WAIT=3. With 16 taps, both saturation limits are reached within a few steps, and each check can compare the whole one-hot word against the expected tap. The short settle window lets the bench check every cycle before recall. It shows that a pending host write is dropped through the recall edge, and that a second reset recalls a new register 0 value.

// File: rtl/wiper_pkg.sv
package wiper_pkg;

    typedef enum logic [1:0] {
        ST_SETTLE,
        ST_RECALL,
        ST_RUN
    } wstate_e;

    typedef enum logic [2:0] {
        OP_HOLD,
        OP_RECALL,
        OP_HOST,
        OP_XFR,
        OP_INC,
        OP_DEC
    } wop_e;

endpackage

// File: rtl/wiper_ctrl.sv
module wiper_ctrl
    import wiper_pkg::*;
#(
    parameter int RECALL_WAIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic host_wr_en,
    input  logic xfr_en,
    input  logic step_en,
    input  logic step_up,
    output wop_e op
);
    localparam int CW = $clog2(RECALL_WAIT + 1);
    localparam logic [CW-1:0] LAST = CW'(RECALL_WAIT - 1);

    wstate_e        state, state_nxt;
    logic [CW-1:0]  wait_cnt;

    // state register and settle counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_SETTLE;
            wait_cnt <= '0;
        end else begin
            state <= state_nxt;
            if (state == ST_SETTLE)
                wait_cnt <= wait_cnt + 1'b1;
        end
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_SETTLE: if (wait_cnt == LAST) state_nxt = ST_RECALL;
            ST_RECALL: state_nxt = ST_RUN;
            ST_RUN:    state_nxt = ST_RUN;
            default:   state_nxt = ST_SETTLE;
        endcase
    end

    // operation decode, priority host > transfer > step (R8)
    always_comb begin
        op = OP_HOLD;
        unique case (state)
            ST_SETTLE: op = OP_HOLD;
            ST_RECALL: op = OP_RECALL;
            ST_RUN: begin
                if (host_wr_en)   op = OP_HOST;
                else if (xfr_en)  op = OP_XFR;
                else if (step_en) op = step_up ? OP_INC : OP_DEC;
                else              op = OP_HOLD;
            end
            default: op = OP_HOLD;
        endcase
    end

    // R3: RUN is only ever entered through a recall cycle
    a_r3_run_after_recall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_RUN) |-> $past(op) == OP_RECALL);

    // R2: recall lasts exactly one cycle
    a_r2_single_recall: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_RECALL) |=> (op != OP_RECALL));

endmodule

// File: rtl/wiper_counter.sv
module wiper_counter
    import wiper_pkg::*;
#(
    parameter int WIDTH  = 8,
    parameter int NUM_DR = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  wop_e                    op,
    input  logic [WIDTH-1:0]        host_code,
    input  logic [$clog2(NUM_DR)-1:0] xfr_sel,
    input  logic [NUM_DR*WIDTH-1:0] dr_flat,
    output logic [WIDTH-1:0]        code,
    output logic [WIDTH-1:0]        code_nxt
);
    localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

    logic [WIDTH-1:0] dr_word [NUM_DR];
    logic [WIDTH-1:0] sel_word;

    for (genvar g = 0; g < NUM_DR; g++) begin : g_split
        assign dr_word[g] = dr_flat[g*WIDTH +: WIDTH];
    end

    assign sel_word = dr_word[xfr_sel];

    always_comb begin
        code_nxt = code;
        unique case (op)
            OP_HOLD:   code_nxt = code;
            OP_RECALL: code_nxt = dr_word[0];
            OP_HOST:   code_nxt = host_code;
            OP_XFR:    code_nxt = sel_word;
            OP_INC:    code_nxt = (code == TOP) ? code : code + 1'b1;
            OP_DEC:    code_nxt = (code == '0) ? code : code - 1'b1;
            default:   code_nxt = code;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) code <= '0;
        else        code <= code_nxt;
    end

    a_r2_recall_dr0: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_RECALL) |=> code == $past(dr_flat[WIDTH-1:0]));

    a_r4_host_load: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_HOST) |=> code == $past(host_code));

    a_r5_xfr_load: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_XFR) |=> code == $past(sel_word));

    a_r6_inc_sat: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_INC && code == TOP) |=> code == TOP);

    a_r6_inc_step: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_INC && code != TOP) |=> code == $past(code) + 1'b1);

    a_r7_dec_sat: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_DEC && code == '0) |=> code == '0);

    a_r7_dec_step: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_DEC && code != '0) |=> code == $past(code) - 1'b1);

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_HOLD) |=> $stable(code));

endmodule

// File: rtl/wiper_tap_decode.sv
module wiper_tap_decode #(
    parameter int WIDTH = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [WIDTH-1:0]      code_nxt,
    output logic [(1<<WIDTH)-1:0] tap_sel
);
    localparam int TAPS = 1 << WIDTH;

    logic [TAPS-1:0] tap_d;

    for (genvar i = 0; i < TAPS; i++) begin : g_tap
        assign tap_d[i] = (code_nxt == WIDTH'(i));
    end

    // registered so the switch word changes in one clean step
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tap_sel <= TAPS'(1);
        else        tap_sel <= tap_d;
    end

    a_r9_single_tap: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(tap_sel));

endmodule

// File: rtl/wiper_position.sv
module wiper_position
    import wiper_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int NUM_DR      = 4,
    parameter int RECALL_WAIT = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        host_wr_en,
    input  logic [WIDTH-1:0]            host_wr_code,
    input  logic                        xfr_en,
    input  logic [$clog2(NUM_DR)-1:0]   xfr_sel,
    input  logic                        step_en,
    input  logic                        step_up,
    input  logic [NUM_DR*WIDTH-1:0]     dr_bank0,
    output logic [WIDTH-1:0]            code,
    output logic [(1<<WIDTH)-1:0]       tap_sel
);
    localparam int TAPS = 1 << WIDTH;

    wop_e             op;
    logic [WIDTH-1:0] code_nxt;

    wiper_ctrl #(.RECALL_WAIT(RECALL_WAIT)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr_en (host_wr_en),
        .xfr_en     (xfr_en),
        .step_en    (step_en),
        .step_up    (step_up),
        .op         (op)
    );

    wiper_counter #(.WIDTH(WIDTH), .NUM_DR(NUM_DR)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (op),
        .host_code (host_wr_code),
        .xfr_sel   (xfr_sel),
        .dr_flat   (dr_bank0),
        .code      (code),
        .code_nxt  (code_nxt)
    );

    wiper_tap_decode #(.WIDTH(WIDTH)) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .code_nxt (code_nxt),
        .tap_sel  (tap_sel)
    );

    // R9: the enabled switch always matches the stored position
    a_r9_tap_tracks_code: assert property (@(posedge clk) disable iff (!rst_n)
        tap_sel == (TAPS'(1) << code));

endmodule

// File: tb/tb_wiper_position.sv
module tb_wiper_position;
    localparam int W    = 4;
    localparam int NDR  = 4;
    localparam int WAIT = 3;
    localparam int NV   = 16;

    // vector: {wr_en, wr_code[4], xfr_en, xfr_sel[2], step_en, step_up, expected[4]}
    localparam logic [13:0] VEC [NV] = '{
        {1'b0, 4'h0, 1'b0, 2'd0, 1'b0, 1'b0, 4'h6},  // R10 idle
        {1'b0, 4'h0, 1'b0, 2'd0, 1'b1, 1'b1, 4'h7},  // R6 up
        {1'b0, 4'h0, 1'b0, 2'd0, 1'b1, 1'b0, 4'h6},  // R7 down
        {1'b1, 4'hD, 1'b0, 2'd0, 1'b0, 1'b0, 4'hD},  // R4 host
        {1'b0, 4'h0, 1'b0, 2'd0, 1'b1, 1'b1, 4'hE},  // R6
        {1'b0, 4'h0, 1'b0, 2'd0, 1'b1, 1'b1, 4'hF},  // R6
        {1'b0, 4'h0, 1'b0, 2'd0, 1'b1, 1'b1, 4'hF},  // R6 saturate
        {1'b0, 4'h0, 1'b1, 2'd1, 1'b0, 1'b0, 4'h3},  // R5 reg1
        {1'b0, 4'h0, 1'b1, 2'd3, 1'b0, 1'b0, 4'hC},  // R5 reg3
        {1'b1, 4'h1, 1'b1, 2'd2, 1'b1, 1'b1, 4'h1},  // R8 host wins
        {1'b0, 4'h0, 1'b1, 2'd2, 1'b1, 1'b1, 4'h9},  // R8 xfr wins
        {1'b0, 4'h0, 1'b0, 2'd0, 1'b1, 1'b0, 4'h8},  // R7
        {1'b1, 4'h0, 1'b0, 2'd0, 1'b0, 1'b0, 4'h0},  // R4
        {1'b0, 4'h0, 1'b0, 2'd0, 1'b1, 1'b0, 4'h0},  // R7 saturate
        {1'b0, 4'h0, 1'b1, 2'd0, 1'b0, 1'b0, 4'h6},  // R5 reg0
        {1'b0, 4'h0, 1'b0, 2'd0, 1'b0, 1'b0, 4'h6}   // R10 idle
    };

    logic           clk = 1'b0;
    logic           rst_n;
    logic           host_wr_en;
    logic [W-1:0]   host_wr_code;
    logic           xfr_en;
    logic [1:0]     xfr_sel;
    logic           step_en;
    logic           step_up;
    logic [NDR*W-1:0] dr_bank0;
    logic [W-1:0]   code;
    logic [15:0]    tap_sel;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    wiper_position #(.WIDTH(W), .NUM_DR(NDR), .RECALL_WAIT(WAIT)) dut (
        .clk(clk), .rst_n(rst_n),
        .host_wr_en(host_wr_en), .host_wr_code(host_wr_code),
        .xfr_en(xfr_en), .xfr_sel(xfr_sel),
        .step_en(step_en), .step_up(step_up),
        .dr_bank0(dr_bank0), .code(code), .tap_sel(tap_sel)
    );

    task automatic check_pos(input string req, input logic [W-1:0] exp);
        checks++;
        if (code !== exp) begin
            fails++;
            $display("FAIL %s code: actual %0h expected %0h", req, code, exp);
        end
        checks++;
        if (tap_sel !== (16'(1) << exp)) begin
            fails++;
            $display("FAIL R9 (%s) tap_sel: actual %h expected %h", req, tap_sel, 16'(1) << exp);
        end
    endtask

    task automatic quiet();
        host_wr_en = 1'b0; host_wr_code = '0; xfr_en = 1'b0;
        xfr_sel = '0; step_en = 1'b0; step_up = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0;
        quiet();
        dr_bank0 = {4'hC, 4'h9, 4'h3, 4'h6};
        step_en = 1'b1; step_up = 1'b1;
        repeat (3) @(negedge clk);
        check_pos("R1 in reset", 4'h0);

        // pending host write held across the settle window and recall edge
        step_en = 1'b0;
        host_wr_en = 1'b1; host_wr_code = 4'hF;
        rst_n = 1'b1;
        for (int k = 0; k < WAIT; k++) begin
            @(negedge clk);
            check_pos("R3 before recall", 4'h0);
        end
        @(negedge clk);
        check_pos("R2 recall of reg0 (R3 strobe dropped)", 4'h6);
        quiet();

        for (int i = 0; i < NV; i++) begin
            host_wr_en   = VEC[i][13];
            host_wr_code = VEC[i][12:9];
            xfr_en       = VEC[i][8];
            xfr_sel      = VEC[i][7:6];
            step_en      = VEC[i][5];
            step_up      = VEC[i][4];
            @(negedge clk);
            check_pos($sformatf("vector %0d (R4-R8,R10)", i), VEC[i][3:0]);
        end
        quiet();

        // asynchronous reset mid-run, then recall of a new register 0
        @(negedge clk);
        rst_n = 1'b0;
        dr_bank0[3:0] = 4'hA;
        #1;
        check_pos("R1 async reset", 4'h0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (WAIT) @(negedge clk);
        check_pos("R3 settle after second reset", 4'h0);
        @(negedge clk);
        check_pos("R2 recall of new reg0", 4'hA);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule